// File: doc/BRIEF.md
# Quadrature Position Counter (x4)

This block turns the two phase signals and the index signal of an incremental encoder into a position count. It counts on every edge of both phases, so one full encoder cycle gives four counts. The count runs between zero and a programmable ceiling and wraps in both directions. The phase inputs are expected to be synchronised and filtered by a separate block upstream.

Each phase can be inverted, and the two phases can be exchanged. A qualified index pulse can preset the count to zero. The index is qualified by a selectable pair of phase levels. Events are collected in a sticky interrupt status vector with a mask, and a single interrupt line results.

Software reaches the block through a small word-addressed register port. Register reads are combinational and writes take effect on the clock edge. The addresses are: 0 control, 1 ceiling, 2 count (read-only), 3 interrupt status, 4 interrupt mask. Any other address reads as zero.

Top module: `qpc_top`

## Requirements
- R1: With control bit 0 (enable) set, a change of exactly one conditioned phase changes the count by one. The direction is up for the sequence {A,B} = 00→10→11→01→00 and down for the reverse.
- R2: An up step taken when the count is at or above the ceiling (address 1) sets the count to zero.
- R3: A down step taken at count zero sets the count to the ceiling value.
- R4: When both conditioned phases change in the same cycle, the count does not change. The same event sets the sticky phase-error flag, control bit 7. Writing the control word with bit 7 = 1 clears this flag, and a new error event takes priority over the clear.
- R5: Control bit 2 inverts phase A, bit 3 inverts phase B and bit 4 inverts the index. Bit 5 exchanges A and B, and the exchange is applied after the inversion.
- R6: While bit 8 is clear, a rising edge of (index AND phase-level match) presets the count to zero. The match is selected by gate field bits 10:9: 0 = A low/B low, 1 = A low/B high, 2 = A high/B low, 3 = A high/B high. While bit 8 is set, the index has no effect.
- R7: An index preset sets status bit 2 when the most recent step was up, and status bit 1 when it was down.
- R8: A step whose direction differs from the previous step sets status bit 3.
- R9: A one-cycle pulse on wdtStrobe sets status bit 0.
- R10: Status bits are cleared by writing 1 to them (address 3). irq is the OR of (status AND NOT mask). The mask resets to 6'h3F, so irq is low whenever the mask holds all six bits. Status bits 5 and 4 always read 0.
- R11: While enable is set, a control write changes only bit 0 and the bit 7 clear. All other control bits keep their values.
- R12: While enable is clear, the count holds, and the phase history keeps tracking the inputs. Because of this, setting enable causes no step.
- R13: After reset, control reads 0, ceiling reads all ones, count reads 0, status reads 0, mask reads 6'h3F and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| phA | input | 1 | Encoder phase A (synchronised) |
| phB | input | 1 | Encoder phase B (synchronised) |
| idx | input | 1 | Encoder index (synchronised) |
| wdtStrobe | input | 1 | One-cycle pulse that raises the watchdog status bit |
| regAddr | input | ADDR_W | Register word address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data for regAddr |
| position | output | DATA_W | Current count |
| irq | output | 1 | Masked interrupt request |

## Verification
The hardest case to reach from the ports is an index preset. It needs the enable bit, the reset-mode bit and the gate field set together. The phases must sit on the selected level pair, and the last step must have the direction under test. The bench gets there by walking the phases through whole quadrature cycles first, so that the direction is known, and only then pulses the index. The simultaneous phase change is driven from the vector table, which moves both phases in one step. The inversion and exchange options are each checked by choosing an edge that would count the other way without the option.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  localparam int ADR_CTRL   = 0;
  localparam int ADR_CEIL   = 1;
  localparam int ADR_COUNT  = 2;
  localparam int ADR_STATUS = 3;
  localparam int ADR_MASK   = 4;
  localparam int IRQ_BITS   = 6;
  localparam int CTRL_BITS  = 11;

  typedef struct packed {
    logic       enable;
    logic       invA;
    logic       invB;
    logic       invIdx;
    logic       swapAB;
    logic       noIdxReset;
    logic [1:0] idxGate;
  } qpc_cfg_t;

  typedef struct packed {
    logic dirChange;
    logic resetUp;
    logic resetDown;
    logic phaseErr;
  } qpc_evt_t;
endpackage

// File: rtl/qpc_datapath.sv
module qpc_datapath
  import qpc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  qpc_cfg_t          cfg,
  input  logic [DATA_W-1:0] ceiling,
  input  logic              phA,
  input  logic              phB,
  input  logic              idx,
  output logic [DATA_W-1:0] count,
  output qpc_evt_t          evt
);
  logic aInv, bInv, qa, qb, qi;
  logic prevA, prevB, prevQual, lastUp;
  logic chA, chB, step, illegal, stepUp, curUp, gateHit, qual, idxFire;

  always_comb begin
    aInv    = phA ^ cfg.invA;
    bInv    = phB ^ cfg.invB;
    qa      = cfg.swapAB ? bInv : aInv;
    qb      = cfg.swapAB ? aInv : bInv;
    qi      = idx ^ cfg.invIdx;
    chA     = qa ^ prevA;
    chB     = qb ^ prevB;
    step    = cfg.enable & (chA ^ chB);
    illegal = cfg.enable & chA & chB;
    stepUp  = chA ? (qa != qb) : (qb == qa);
    curUp   = step ? stepUp : lastUp;
    gateHit = ({qa, qb} == cfg.idxGate);
    qual    = qi & gateHit;
    idxFire = cfg.enable & ~cfg.noIdxReset & qual & ~prevQual;
    evt.dirChange = step & (stepUp != lastUp);
    evt.resetUp   = idxFire & curUp;
    evt.resetDown = idxFire & ~curUp;
    evt.phaseErr  = illegal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevA    <= 1'b0;
      prevB    <= 1'b0;
      prevQual <= 1'b0;
      lastUp   <= 1'b1;
      count    <= '0;
    end else begin
      prevA    <= qa;
      prevB    <= qb;
      prevQual <= qual;
      if (step) lastUp <= stepUp;
      if (idxFire) begin
        count <= '0;
      end else if (step) begin
        if (stepUp) count <= (count >= ceiling) ? '0 : count + 1'b1;
        else        count <= (count == '0) ? ceiling : count - 1'b1;
      end
    end
  end
endmodule

// File: rtl/qpc_ctrl.sv
module qpc_ctrl
  import qpc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter logic [DATA_W-1:0] CEIL_INIT = '1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWrEn,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  input  logic [DATA_W-1:0]     count,
  input  qpc_evt_t              evt,
  input  logic                  wdtStrobe,
  output qpc_cfg_t              cfg,
  output logic [DATA_W-1:0]     ceiling,
  output logic [CTRL_BITS-1:0]  ctrlWord,
  output logic [IRQ_BITS-1:0]   status,
  output logic [IRQ_BITS-1:0]   mask,
  output logic                  irq
);
  logic fltEn, opMode, phErr;
  logic wrCtrl, wrCeil, wrStatus, wrMask;
  logic [IRQ_BITS-1:0] setVec, clrVec;

  always_comb begin
    wrCtrl   = regWrEn && (regAddr == ADDR_W'(ADR_CTRL));
    wrCeil   = regWrEn && (regAddr == ADDR_W'(ADR_CEIL));
    wrStatus = regWrEn && (regAddr == ADDR_W'(ADR_STATUS));
    wrMask   = regWrEn && (regAddr == ADDR_W'(ADR_MASK));
    setVec   = {2'b00, evt.dirChange, evt.resetUp, evt.resetDown, wdtStrobe};
    clrVec   = wrStatus ? regWrData[IRQ_BITS-1:0] : '0;
    ctrlWord = {cfg.idxGate, cfg.noIdxReset, phErr, opMode, cfg.swapAB,
                cfg.invIdx, cfg.invB, cfg.invA, fltEn, cfg.enable};
    irq      = |(status & ~mask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg     <= '0;
      fltEn   <= 1'b0;
      opMode  <= 1'b0;
      phErr   <= 1'b0;
      ceiling <= CEIL_INIT;
      status  <= '0;
      mask    <= '1;
    end else begin
      phErr  <= (phErr & ~(wrCtrl & regWrData[7])) | evt.phaseErr;
      status <= (status & ~clrVec) | setVec;
      if (wrCeil) ceiling <= regWrData;
      if (wrMask) mask <= regWrData[IRQ_BITS-1:0];
      if (wrCtrl) begin
        cfg.enable <= regWrData[0];
        if (!cfg.enable) begin
          fltEn          <= regWrData[1];
          cfg.invA       <= regWrData[2];
          cfg.invB       <= regWrData[3];
          cfg.invIdx     <= regWrData[4];
          cfg.swapAB     <= regWrData[5];
          opMode         <= regWrData[6];
          cfg.noIdxReset <= regWrData[8];
          cfg.idxGate    <= regWrData[10:9];
        end
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_W'(ADR_CTRL):   regRdData = DATA_W'(ctrlWord);
      ADDR_W'(ADR_CEIL):   regRdData = ceiling;
      ADDR_W'(ADR_COUNT):  regRdData = count;
      ADDR_W'(ADR_STATUS): regRdData = DATA_W'(status);
      ADDR_W'(ADR_MASK):   regRdData = DATA_W'(mask);
      default:             regRdData = '0;
    endcase
  end
endmodule

// File: rtl/qpc_top.sv
module qpc_top
  import qpc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              phA,
  input  logic              phB,
  input  logic              idx,
  input  logic              wdtStrobe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0] position,
  output logic              irq
);
  qpc_cfg_t             cfg;
  qpc_evt_t             evt;
  logic [DATA_W-1:0]    ceiling;
  logic [CTRL_BITS-1:0] ctrlWord;
  logic [IRQ_BITS-1:0]  status;
  logic [IRQ_BITS-1:0]  mask;

  qpc_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .count(position),
    .evt(evt), .wdtStrobe(wdtStrobe), .cfg(cfg), .ceiling(ceiling),
    .ctrlWord(ctrlWord), .status(status), .mask(mask), .irq(irq)
  );

  qpc_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .ceiling(ceiling),
    .phA(phA), .phB(phB), .idx(idx), .count(position), .evt(evt)
  );
endmodule

// File: rtl/qpc_checker.sv
module qpc_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              en,
  input logic [DATA_W-1:0] ceil,
  input logic [DATA_W-1:0] position,
  input logic              wdt,
  input logic [5:0]        status,
  input logic [5:0]        mask,
  input logic              irq,
  input logic              wrCtrl,
  input logic              wrBit7,
  input logic              phErr,
  input logic [8:0]        lockedBits
);
  // R1 R2 R3: one edge moves the count by one, or wraps, or presets it
  p_single_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    en |=> (position == $past(position)) || (position == $past(position) + 1'b1) ||
           (position == $past(position) - 1'b1) || (position == '0) ||
           (position == $past(ceil)));

  p_hold_disabled_r12: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> $stable(position));

  p_sticky_err_r4: assert property (@(posedge clk) disable iff (!rstN)
    phErr && !(wrCtrl && wrBit7) |=> phErr);

  p_locked_cfg_r11: assert property (@(posedge clk) disable iff (!rstN)
    en && wrCtrl |=> $stable(lockedBits));

  p_wdt_sets_r9: assert property (@(posedge clk) disable iff (!rstN)
    wdt |=> status[0]);

  p_mask_all_r10: assert property (@(posedge clk) disable iff (!rstN)
    (mask == 6'h3F) |-> !irq);

  p_fifo_bits_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    status[5:4] == 2'b00);
endmodule

bind qpc_top qpc_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .en(cfg.enable), .ceil(ceiling), .position(position),
  .wdt(wdtStrobe), .status(status), .mask(mask), .irq(irq),
  .wrCtrl(regWrEn && (regAddr == '0)), .wrBit7(regWrData[7]),
  .phErr(ctrlWord[7]), .lockedBits({ctrlWord[10:8], ctrlWord[6:1]})
);

// File: tb/tb_qpc_top.sv
module tb_qpc_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        phA = 1'b0, phB = 1'b0, idx = 1'b0, wdtStrobe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData, position;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  qpc_top dut (.*);

  // {phA, phB, expected count}; ceiling 5, index preset off
  localparam logic [33:0] VEC [12] = '{
    {2'b10, 32'd1}, {2'b11, 32'd2}, {2'b01, 32'd3}, {2'b00, 32'd4},
    {2'b10, 32'd5}, {2'b11, 32'd0}, {2'b10, 32'd5}, {2'b00, 32'd4},
    {2'b11, 32'd4}, {2'b10, 32'd3}, {2'b11, 32'd4}, {2'b01, 32'd5}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #1 d = regRdData;
  endtask

  task automatic setIn(logic a, logic b, logic i);
    @(negedge clk); phA = a; phB = b; idx = i;
    @(negedge clk);
  endtask

  function automatic string vecReq(int i);
    if (i == 5) return "R2";
    if (i == 6) return "R3";
    if (i == 8) return "R4";
    return "R1";
  endfunction

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R13 reset state
    rd(0, v); chk("R13 ctrl", v, 32'h0);
    rd(1, v); chk("R13 ceiling", v, 32'hFFFF_FFFF);
    rd(2, v); chk("R13 count", v, 32'h0);
    rd(3, v); chk("R13 status", v, 32'h0);
    rd(4, v); chk("R13 mask", v, 32'h3F);
    chk("R13 irq", {31'd0, irq}, 32'h0);

    wr(1, 32'd5);
    wr(0, 32'h101);
    for (int i = 0; i < 12; i++) begin
      setIn(VEC[i][33], VEC[i][32], 1'b0);
      chk(vecReq(i), position, VEC[i][31:0]);
    end
    rd(0, v); chk("R4 flag set", v & 32'h80, 32'h80);
    rd(3, v); chk("R8 dir change", v, 32'h08);
    wr(0, 32'h81);                      // clear flag; other bits locked
    rd(0, v); chk("R11 locked / R4 clear", v, 32'h101);

    // R12 disabled: hold and no spurious step on enable
    wr(0, 32'h100);
    setIn(0, 0, 0); chk("R12 hold", position, 32'd5);
    setIn(1, 1, 0); chk("R12 hold", position, 32'd5);
    rd(0, v); chk("R12 no error when off", v, 32'h100);
    wr(0, 32'h101);
    setIn(1, 1, 0); chk("R12 enable no step", position, 32'd5);

    // R6 R7 index presets
    wr(1, 32'd100);
    wr(0, 32'h100);
    wr(0, 32'h601);
    setIn(0, 1, 0); setIn(0, 0, 0); setIn(1, 0, 0); setIn(1, 1, 0);
    chk("R1 up steps", position, 32'd9);
    wr(3, 32'h3F);
    setIn(1, 1, 1); chk("R6 preset", position, 32'd0);
    setIn(1, 1, 0);
    rd(3, v); chk("R7 reset up", v, 32'h04);
    setIn(1, 0, 0); chk("R3 wrap", position, 32'd100);
    setIn(0, 0, 0); setIn(0, 1, 0); setIn(1, 1, 0);
    chk("R1 down steps", position, 32'd97);
    wr(3, 32'h3F);
    setIn(1, 1, 1); setIn(1, 1, 0);
    chk("R6 preset down", position, 32'd0);
    rd(3, v); chk("R7 reset down", v, 32'h02);
    setIn(0, 1, 0); chk("R1 up", position, 32'd1);
    wr(0, 32'h200);
    wr(0, 32'h001);                     // gate A0B0, inputs A0B1
    setIn(0, 1, 1); setIn(0, 1, 0);
    chk("R6 gate mismatch", position, 32'd1);
    wr(0, 32'h000);
    wr(0, 32'h301);                     // gate matches, preset off
    setIn(0, 1, 1); setIn(0, 1, 0);
    chk("R6 preset disabled", position, 32'd1);
    wr(0, 32'h300);
    wr(0, 32'h201);
    setIn(0, 1, 1); setIn(0, 1, 0);
    chk("R6 gate A0B1", position, 32'd0);

    // R5 inversion and exchange
    wr(0, 32'h200);
    wr(0, 32'h104);
    setIn(0, 0, 0);
    wr(0, 32'h105);
    setIn(0, 1, 0); chk("R5 invert A", position, 32'd1);
    wr(0, 32'h104);
    wr(0, 32'h120);
    setIn(0, 0, 0);
    wr(0, 32'h121);
    setIn(0, 1, 0); chk("R5 swap", position, 32'd2);

    // R9 R10 interrupts
    wr(3, 32'h3F);
    @(negedge clk); wdtStrobe = 1'b1;
    @(negedge clk); wdtStrobe = 1'b0;
    rd(3, v); chk("R9 wdt", v, 32'h01);
    chk("R10 masked", {31'd0, irq}, 32'h0);
    wr(4, 32'h3E);
    chk("R10 unmasked", {31'd0, irq}, 32'h1);
    wr(3, 32'h01);
    rd(3, v); chk("R10 w1c", v, 32'h0);
    chk("R10 irq low", {31'd0, irq}, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule